// File: doc/BRIEF.md
# SPI Chip-Select Sequencer

This block owns the four chip-select lines of a burst-oriented SPI master. It does not shift data and holds no FIFO. It takes decoded register fields and event strobes from the surrounding controller and decides, clock by clock, which select line is driven to its active level. The register fields are the enable bit, the channel number, the per-line polarity and the per-channel burst mode. The strobes mark a TX FIFO flush starting, a burst starting or ending, the TX FIFO running empty, a write to the interrupt-enable register, a write to the status register, a set of the exchange bit, and a receive overflow.

Each channel runs in one of two modes. In per-burst mode the select line drops at the end of every burst. In multi-burst mode the line stays asserted across bursts. It is released only when software writes zero to the interrupt-enable register after at least two FIFO flushes. The block also holds the transfer-complete and receive-overflow status flags and the exchange-in-progress bit.

Top module: `spi_cs_seq`

## Requirements
- R1: While reset is held, and on the first edge after it is released, all four select outputs are 1 and the transfer-complete, receive-overflow and exchange outputs are 0.
- R2: Line i is active when its output equals polarity bit i (bit set means active-high). A polarity change with no other stimulus appears on the outputs on the next clock edge.
- R3: A flush-start strobe drives every line other than the one picked by the channel field to its inactive level on the next edge.
- R4: A burst-start strobe drives the selected line to its active level on the next edge.
- R5: When waveform bit [channel] is 0 (per-burst mode), a burst-end strobe drives the selected line inactive on the next edge. This release wins over a burst-start in the same cycle.
- R6: When waveform bit [channel] is 1 (multi-burst mode), a burst-end strobe leaves the selected line unchanged. Each flush-start in this mode increments a saturating flush counter.
- R7: An interrupt-enable write whose data is all zero, while the flush counter exceeds 1, drives the selected line inactive and clears the counter. With a nonzero value or a counter of 0 or 1 it has no effect.
- R8: A TX-empty strobe sets transfer-complete and clears exchange. An exchange-set strobe sets exchange. The clear wins when both occur.
- R9: A status write clears transfer-complete where data bit 0 is 1 and receive-overflow where data bit 1 is 1. Other data bits are ignored. A set in the same cycle wins over the clear.
- R10: While enable is 0, every line sits inactive at its own polarity, the flush counter is cleared, and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low resets the sequencing state |
| chanSel | input | 2 | Selected channel |
| csPolarity | input | 4 | Per-line active level, 1 = active-high |
| waveCtl | input | 4 | Per-channel mode, 1 = multi-burst |
| flushStart | input | 1 | TX FIFO flush begins |
| burstStart | input | 1 | A new burst begins |
| burstEnd | input | 1 | Current burst length used up |
| txEmpty | input | 1 | TX FIFO has become empty |
| xchSet | input | 1 | Software sets the exchange bit |
| rxOverflow | input | 1 | Receive overflow event |
| intEnWr | input | 1 | Write to the interrupt-enable register |
| intEnData | input | 8 | Data of that write |
| statWr | input | 1 | Write to the status register |
| statWrData | input | 4 | Data of that write |
| csOut | output | 4 | Chip-select lines |
| tcFlag | output | 1 | Transfer-complete status |
| roFlag | output | 1 | Receive-overflow status |
| xchBusy | output | 1 | Exchange-in-progress bit |

## Verification
The flush counter has no port of its own. A wrong count shows only at the interrupt-enable write of zero: the selected line either drops one write too early or stays asserted one write too long. That difference is visible on csOut one edge after the write. A wrong per-line asserted state appears on csOut at the edge after the strobe that should have changed it. A mixed polarity pattern across the lines separates an inverted-level bug from a wrong-line bug. The reference model is compared on every cycle, so any divergence is reported within one clock of its cause.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  // Commands from control to the select-line datapath for one cycle.
  typedef struct packed {
    logic releaseAll;     // every line to inactive
    logic releaseOthers;  // non-selected lines to inactive
    logic assertSel;      // selected line to active
    logic releaseSel;     // selected line to inactive (wins over assertSel)
  } csCmd_t;
endpackage

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl
  import spi_cs_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int INT_W  = 8,
  parameter int STAT_W = 4,
  parameter int CNT_W  = 3,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [SEL_W-1:0]  chanSel,
  input  logic [NUM_CS-1:0] waveCtl,
  input  logic              flushStart,
  input  logic              burstStart,
  input  logic              burstEnd,
  input  logic              txEmpty,
  input  logic              xchSet,
  input  logic              rxOverflow,
  input  logic              intEnWr,
  input  logic [INT_W-1:0]  intEnData,
  input  logic              statWr,
  input  logic [STAT_W-1:0] statWrData,
  output csCmd_t            cmd,
  output logic              tcFlag,
  output logic              roFlag,
  output logic              xchBusy
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] flushCnt;
  logic multiMode;
  logic zeroRelease;

  assign multiMode   = waveCtl[chanSel];
  assign zeroRelease = intEnWr && (intEnData == '0) && (flushCnt > CNT_W'(1));

  always_comb begin
    cmd.releaseAll    = !enable;
    cmd.releaseOthers = flushStart;
    cmd.assertSel     = burstStart;
    cmd.releaseSel    = (burstEnd && !multiMode) || zeroRelease;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flushCnt <= '0;
    end else if (!enable || zeroRelease) begin
      flushCnt <= '0;
    end else if (flushStart && multiMode && flushCnt != CNT_MAX) begin
      flushCnt <= flushCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tcFlag  <= 1'b0;
      roFlag  <= 1'b0;
      xchBusy <= 1'b0;
    end else if (!enable) begin
      tcFlag  <= 1'b0;
      roFlag  <= 1'b0;
      xchBusy <= 1'b0;
    end else begin
      if (txEmpty)                       tcFlag <= 1'b1;
      else if (statWr && statWrData[0])  tcFlag <= 1'b0;
      if (rxOverflow)                    roFlag <= 1'b1;
      else if (statWr && statWrData[1])  roFlag <= 1'b0;
      if (txEmpty)                       xchBusy <= 1'b0;
      else if (xchSet)                   xchBusy <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_cs_datapath.sv
module spi_cs_datapath
  import spi_cs_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter logic [NUM_CS-1:0] RESET_POL = '0,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  csCmd_t            cmd,
  input  logic [SEL_W-1:0]  chanSel,
  input  logic [NUM_CS-1:0] csPolarity,
  output logic [NUM_CS-1:0] csOut
);
  logic [NUM_CS-1:0] activeQ;
  logic [NUM_CS-1:0] activeNext;
  logic [NUM_CS-1:0] selMask;

  assign selMask = NUM_CS'(1) << chanSel;

  always_comb begin
    activeNext = activeQ;
    if (cmd.releaseAll) begin
      activeNext = '0;
    end else begin
      if (cmd.releaseOthers) activeNext = activeNext & selMask;
      if (cmd.assertSel)     activeNext = activeNext | selMask;
      if (cmd.releaseSel)    activeNext = activeNext & ~selMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) activeQ <= '0;
    else       activeQ <= activeNext;
  end

  // One output register per line: active drives the polarity level.
  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) csOut[i] <= ~RESET_POL[i];
      else       csOut[i] <= activeNext[i] ? csPolarity[i] : ~csPolarity[i];
    end
  end
endmodule

// File: rtl/spi_cs_seq.sv
module spi_cs_seq
  import spi_cs_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int INT_W  = 8,
  parameter int STAT_W = 4,
  parameter int CNT_W  = 3,
  parameter logic [NUM_CS-1:0] RESET_POL = '0,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [SEL_W-1:0]  chanSel,
  input  logic [NUM_CS-1:0] csPolarity,
  input  logic [NUM_CS-1:0] waveCtl,
  input  logic              flushStart,
  input  logic              burstStart,
  input  logic              burstEnd,
  input  logic              txEmpty,
  input  logic              xchSet,
  input  logic              rxOverflow,
  input  logic              intEnWr,
  input  logic [INT_W-1:0]  intEnData,
  input  logic              statWr,
  input  logic [STAT_W-1:0] statWrData,
  output logic [NUM_CS-1:0] csOut,
  output logic              tcFlag,
  output logic              roFlag,
  output logic              xchBusy
);
  csCmd_t cmd;

  spi_cs_ctrl #(
    .NUM_CS(NUM_CS), .INT_W(INT_W), .STAT_W(STAT_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .chanSel(chanSel),
    .waveCtl(waveCtl), .flushStart(flushStart), .burstStart(burstStart),
    .burstEnd(burstEnd), .txEmpty(txEmpty), .xchSet(xchSet),
    .rxOverflow(rxOverflow), .intEnWr(intEnWr), .intEnData(intEnData),
    .statWr(statWr), .statWrData(statWrData), .cmd(cmd),
    .tcFlag(tcFlag), .roFlag(roFlag), .xchBusy(xchBusy)
  );

  spi_cs_datapath #(
    .NUM_CS(NUM_CS), .RESET_POL(RESET_POL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .chanSel(chanSel),
    .csPolarity(csPolarity), .csOut(csOut)
  );
endmodule

// File: rtl/spi_cs_seq_chk.sv
module spi_cs_seq_chk #(
  parameter int NUM_CS = 4,
  parameter int STAT_W = 4,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic [SEL_W-1:0]  chanSel,
  input logic [NUM_CS-1:0] csPolarity,
  input logic [NUM_CS-1:0] waveCtl,
  input logic              flushStart,
  input logic              burstStart,
  input logic              burstEnd,
  input logic              txEmpty,
  input logic              xchSet,
  input logic              statWr,
  input logic [STAT_W-1:0] statWrData,
  input logic [NUM_CS-1:0] csOut,
  input logic              tcFlag,
  input logic              xchBusy
);
  // R10: disabled means every line at its inactive level
  p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> csOut == ~$past(csPolarity));

  // R3: after a flush start at most one line remains active
  p_flush_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    enable && flushStart |=> $onehot0(~(csOut ^ $past(csPolarity))));

  // R4: burst start asserts the selected line when nothing releases it
  p_burst_assert_r4: assert property (@(posedge clk) disable iff (!rstN)
    enable && burstStart && !burstEnd |=>
      csOut[$past(chanSel)] == $past(csPolarity[chanSel]));

  // R5: per-burst mode releases at burst end
  p_burst_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    enable && burstEnd && !waveCtl[chanSel] |=>
      csOut[$past(chanSel)] != $past(csPolarity[chanSel]));

  // R8: TX empty sets complete and clears exchange
  p_empty_flags_r8: assert property (@(posedge clk) disable iff (!rstN)
    enable && txEmpty |=> tcFlag && !xchBusy);

  // R8: exchange set without empty raises the bit
  p_xch_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    enable && xchSet && !txEmpty |=> xchBusy);

  // R9: write-one clears transfer complete
  p_tc_w1c_r9: assert property (@(posedge clk) disable iff (!rstN)
    enable && statWr && statWrData[0] && !txEmpty |=> !tcFlag);
endmodule

bind spi_cs_seq spi_cs_seq_chk #(.NUM_CS(NUM_CS), .STAT_W(STAT_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .chanSel(chanSel),
  .csPolarity(csPolarity), .waveCtl(waveCtl), .flushStart(flushStart),
  .burstStart(burstStart), .burstEnd(burstEnd), .txEmpty(txEmpty),
  .xchSet(xchSet), .statWr(statWr), .statWrData(statWrData),
  .csOut(csOut), .tcFlag(tcFlag), .xchBusy(xchBusy)
);

// File: tb/spi_cs_seq_tb.sv
module spi_cs_seq_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [1:0] chanSel = '0;
  logic [3:0] csPolarity = '0, waveCtl = '0;
  logic flushStart = 0, burstStart = 0, burstEnd = 0, txEmpty = 0;
  logic xchSet = 0, rxOverflow = 0, intEnWr = 0, statWr = 0;
  logic [7:0] intEnData = '0;
  logic [3:0] statWrData = '0;
  logic [3:0] csOut;
  logic tcFlag, roFlag, xchBusy;

  int errors = 0;
  int checks = 0;
  string tag = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_cs_seq u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .chanSel(chanSel),
    .csPolarity(csPolarity), .waveCtl(waveCtl), .flushStart(flushStart),
    .burstStart(burstStart), .burstEnd(burstEnd), .txEmpty(txEmpty),
    .xchSet(xchSet), .rxOverflow(rxOverflow), .intEnWr(intEnWr),
    .intEnData(intEnData), .statWr(statWr), .statWrData(statWrData),
    .csOut(csOut), .tcFlag(tcFlag), .roFlag(roFlag), .xchBusy(xchBusy)
  );

  // Behavioural reference model
  bit [3:0] mAct, mOut;
  bit mTc, mRo, mXch;
  int mCnt;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAct = 0; mOut = 4'hF; mCnt = 0; mTc = 0; mRo = 0; mXch = 0;
    end else if (!enable) begin
      mAct = 0; mOut = ~csPolarity; mCnt = 0; mTc = 0; mRo = 0; mXch = 0;
    end else begin
      bit multi, zero;
      int oldCnt;
      multi = waveCtl[chanSel];
      oldCnt = mCnt;
      zero = intEnWr && intEnData == 0 && oldCnt > 1;
      if (flushStart) begin
        for (int i = 0; i < 4; i++) if (i != chanSel) mAct[i] = 0;
        if (multi && mCnt < 7) mCnt++;
      end
      if (zero) mCnt = 0;
      if (burstStart) mAct[chanSel] = 1;
      if ((burstEnd && !multi) || zero) mAct[chanSel] = 0;
      for (int i = 0; i < 4; i++) mOut[i] = mAct[i] ? csPolarity[i] : ~csPolarity[i];
      if (statWr && statWrData[0]) mTc = 0;
      if (txEmpty) mTc = 1;
      if (statWr && statWrData[1]) mRo = 0;
      if (rxOverflow) mRo = 1;
      if (xchSet) mXch = 1;
      if (txEmpty) mXch = 0;
    end
  end

  task automatic compare();
    checks++;
    if (csOut !== mOut || tcFlag !== mTc || roFlag !== mRo || xchBusy !== mXch) begin
      errors++;
      $display("FAIL %s: cs=%b tc=%b ro=%b xch=%b expected cs=%b tc=%b ro=%b xch=%b",
               tag, csOut, tcFlag, roFlag, xchBusy, mOut, mTc, mRo, mXch);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    compare();
    flushStart = 0; burstStart = 0; burstEnd = 0; txEmpty = 0;
    xchSet = 0; rxOverflow = 0; intEnWr = 0; statWr = 0;
    intEnData = '0; statWrData = '0;
  endtask

  task automatic zeroWrite(input logic [7:0] d);
    intEnWr = 1; intEnData = d; tick();
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (3) tick();
    rstN = 1; tick();
    enable = 1; tick();

    // R4: burst start asserts line 0 (active-low)
    tag = "R4";
    burstStart = 1; tick(); tick();
    // R5: per-burst release, then release wins over same-cycle start
    tag = "R5";
    burstEnd = 1; tick();
    burstStart = 1; burstEnd = 1; tick(); tick();

    // R2: mixed polarity, active-high line 2
    tag = "R2";
    csPolarity = 4'b0101; chanSel = 2; tick();
    burstStart = 1; tick();
    csPolarity = 4'b1100; tick(); tick();

    // R3: move to line 1, flush releases line 2
    tag = "R3";
    chanSel = 1; burstStart = 1; tick();
    flushStart = 1; tick(); tick();

    // R6: multi-burst mode on channel 1 keeps the line through burst end
    tag = "R6";
    waveCtl = 4'b0010;
    burstEnd = 1; tick();
    burstStart = 1; tick();
    burstEnd = 1; tick(); tick();

    // R7: zero write gated by flush count and data value
    tag = "R7";
    zeroWrite(8'h00);
    flushStart = 1; tick();
    zeroWrite(8'h00);
    flushStart = 1; tick();
    zeroWrite(8'h04);
    zeroWrite(8'h00);
    burstStart = 1; tick();
    zeroWrite(8'h00);
    tick();

    // R8: exchange and transfer complete
    tag = "R8";
    xchSet = 1; tick();
    txEmpty = 1; tick();
    xchSet = 1; tick();
    xchSet = 1; txEmpty = 1; tick();

    // R9: write-one-to-clear
    tag = "R9";
    rxOverflow = 1; tick();
    statWr = 1; statWrData = 4'b1100; tick();
    statWr = 1; statWrData = 4'b0001; tick();
    statWr = 1; statWrData = 4'b0010; tick();
    txEmpty = 1; tick();
    statWr = 1; statWrData = 4'b0001; txEmpty = 1; tick();
    rxOverflow = 1; statWr = 1; statWrData = 4'b0010; tick();

    // R10: disable clears lines, flags and flush counter
    tag = "R10";
    flushStart = 1; tick();
    flushStart = 1; tick();
    burstStart = 1; tick();
    csPolarity = 4'b0110; enable = 0; tick(); tick();
    enable = 1; tick();
    flushStart = 1; tick();
    burstStart = 1; tick();
    zeroWrite(8'h00);
    tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule